// File: doc/BRIEF.md
# GPIO Port with Power-Down Pad Control

This block is an 8-pin general-purpose I/O port. A small register bank sits behind a single-cycle bus. It holds one output bit per pin, a 2-bit pull choice per pin and a 2-bit drive-strength code per pin. It also holds two sleep registers: one gives each pin a sleep behaviour, and the other gives each pin a sleep pull choice. In normal running, each pin takes its behaviour from a mode input. In input mode the pad is released and its synchronized level is readable. In output mode the pad drives the stored bit. In alternate mode an external function drives the pad.

While the power-down input is held, a two-state power controller moves the pads onto the sleep settings. Each pin can then be driven low, driven high, released, or held at the value it was driving just before sleep began. The sleep pull choice replaces the normal pull. The controller has the states `ST_RUN` and `ST_SLEEP`. Two transitions join them. **enter**: in `ST_RUN` with power-down sampled high, the controller goes to `ST_SLEEP` and captures every pin's output enable and output value. **wake**: in `ST_SLEEP` with power-down sampled low, it goes to `ST_RUN`. In any other case the controller stays in its state. The pads follow the registered state, so every change shows one clock edge after power-down is sampled. Power-down never alters any register.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset the data, drive, sleep-behaviour and sleep-pull registers read 0 and the pull register reads 0x5555. With every pin in input mode, every pad then has pull-down on, pull-up off and output enable off.
- R2: The registers sit at word index 0 (data, 8 bits), 1 (pull, 16 bits), 2 (drive, 16 bits), 3 (sleep behaviour, 16 bits) and 4 (sleep pull, 16 bits). Pin n uses bits [2n+1:2n] of the 2-bit-per-pin registers, and unused upper bits read 0. A read issued with valid high and write low returns its word on `bus_rdata` after that clock edge. Word indices 5 to 7 read 0, and writes to them change no register.
- R3: Mode codes per pin are 00 input, 01 output, 10 alternate and 11 reserved, which acts as input. A read of the data register returns, for each pin, the pad level through a two-flop synchronizer in input or reserved mode, the stored data bit in output mode, and 0 in alternate mode. A pad change is seen by a read whose capturing edge is the third edge after the change, and not by one at the second edge.
- R4: Outside sleep, output mode gives output enable 1 with the stored data bit. Alternate mode passes `alt_oe`/`alt_out` through. Input and reserved modes give output enable 0 and output value 0.
- R5: Pull codes are 00 none, 01 pull-down, 10 pull-up and 11 none. Pull-up and pull-down are never both on.
- R6: The drive code maps to a linear pad strength: 00 gives 0 (1x), 10 gives 1 (2x), 01 gives 2 (3x), 11 gives 3 (4x). The drive setting applies both in and out of sleep.
- R7: One edge after power-down is sampled high, each pin follows its sleep code: 00 gives enable 1 and value 0, 01 gives enable 1 and value 1, 10 gives enable 0 and value 0. The sleep pull register replaces the normal pull. Before that edge the pads still show normal settings.
- R8: A pin with sleep code 11 holds, for the whole sleep, the enable and value it had at the entering edge, even if the mode or data changes meanwhile.
- R9: One edge after power-down is sampled low, the normal mode, data and pull settings apply again. Register contents written before or during sleep are unaffected by sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_mode | input | 16 | 2-bit mode per pin |
| alt_oe | input | 8 | Alternate-function output enables |
| alt_out | input | 8 | Alternate-function output values |
| pad_in | input | 8 | Asynchronous pad levels |
| pd_in | input | 1 | Power-down request, synchronous to clk |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pull-up enables |
| pad_pd | output | 8 | Pull-down enables |
| pad_drv | output | 16 | Linear drive strength, 2 bits per pin |

## Verification
On every cycle the assertions check four things. Pull-up and pull-down are never both on. An output-mode pin outside sleep drives its stored bit. The drive strength keeps the same set-bit count as its code. A retained pin holds steady through sleep. They also check that the controller enters and leaves sleep one edge after `pd_in`, that the captured enables and values equal those of the entering edge, and that writes to unused indices leave every register alone. Only the bench scenarios can show the rest: the reset values and the register map, the sweeps over mode, pull and drive codes, the exact synchronizer latency, the sleep outputs per sleep code, and the restoring of updated settings on wake.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_OUTPUT = 2'b01,
        PM_ALT    = 2'b10,
        PM_RSVD   = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SC_DRIVE0 = 2'b00,
        SC_DRIVE1 = 2'b01,
        SC_FLOAT  = 2'b10,
        SC_RETAIN = 2'b11
    } sleep_cfg_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } pwr_state_e;

    localparam int unsigned REG_DATA   = 0;
    localparam int unsigned REG_PULL   = 1;
    localparam int unsigned REG_DRV    = 2;
    localparam int unsigned REG_PDCFG  = 3;
    localparam int unsigned REG_PDPULL = 4;

    // returns {pull_up, pull_down}
    function automatic logic [1:0] pull_decode(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b01:   r = 2'b01;
            2'b10:   r = 2'b10;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    // scrambled drive code to linear strength
    function automatic logic [1:0] drive_linear(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b00: r = 2'd0;
            2'b10: r = 2'd1;
            2'b01: r = 2'd2;
            2'b11: r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]     rd_pins,
    output logic [NPINS-1:0]     data_q,
    output logic [2*NPINS-1:0]   pull_q,
    output logic [2*NPINS-1:0]   drv_q,
    output logic [2*NPINS-1:0]   pdcfg_q,
    output logic [2*NPINS-1:0]   pdpull_q
);
    localparam int FW = 2 * NPINS;
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);
    localparam logic [ADDR_W-1:0] A_PULL   = ADDR_W'(REG_PULL);
    localparam logic [ADDR_W-1:0] A_DRV    = ADDR_W'(REG_DRV);
    localparam logic [ADDR_W-1:0] A_PDCFG  = ADDR_W'(REG_PDCFG);
    localparam logic [ADDR_W-1:0] A_PDPULL = ADDR_W'(REG_PDPULL);
    localparam logic [FW-1:0]     PULL_RST = {NPINS{2'b01}};

    logic wr_en, rd_en;
    logic [DATA_W-1:0] rd_word;
    logic unused_wdata_hi;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:FW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            pull_q   <= PULL_RST;
            drv_q    <= '0;
            pdcfg_q  <= '0;
            pdpull_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_DATA:   data_q   <= bus_wdata[NPINS-1:0];
                A_PULL:   pull_q   <= bus_wdata[FW-1:0];
                A_DRV:    drv_q    <= bus_wdata[FW-1:0];
                A_PDCFG:  pdcfg_q  <= bus_wdata[FW-1:0];
                A_PDPULL: pdpull_q <= bus_wdata[FW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            A_DATA:   rd_word[NPINS-1:0] = rd_pins;
            A_PULL:   rd_word[FW-1:0]    = pull_q;
            A_DRV:    rd_word[FW-1:0]    = drv_q;
            A_PDCFG:  rd_word[FW-1:0]    = pdcfg_q;
            A_PDPULL: rd_word[FW-1:0]    = pdpull_q;
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_word;
    end

    // R2: a write to an unused index leaves every register alone
    assert_unused_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr > A_PDPULL) |=>
        ($stable(data_q) && $stable(pull_q) && $stable(drv_q) &&
         $stable(pdcfg_q) && $stable(pdpull_q)));

endmodule

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_sync
);
    logic [STAGES-1:0][NPINS-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pad_in};
    end

    assign pad_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pd_fsm.sv
module gpio_pd_fsm
    import gpio_pd_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_in,
    input  logic [NPINS-1:0] norm_oe,
    input  logic [NPINS-1:0] norm_out,
    output logic             asleep,
    output logic [NPINS-1:0] held_oe,
    output logic [NPINS-1:0] held_out
);
    pwr_state_e state_q, state_d;
    logic       capture;

    // next-state logic: transitions "enter" and "wake"
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (pd_in) begin
                    state_d = ST_SLEEP;
                    capture = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!pd_in) state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_oe  <= '0;
            held_out <= '0;
        end else if (capture) begin
            held_oe  <= norm_oe;
            held_out <= norm_out;
        end
    end

    always_comb begin
        asleep = (state_q == ST_SLEEP);
    end

    // R7: power-down sampled high in run enters sleep on that edge
    assert_enter_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && pd_in) |=> asleep);

    // R9: power-down sampled low in sleep wakes on that edge
    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !pd_in) |=> !asleep);

    // R8: retained values are those present at the entering edge
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && pd_in) |=>
        (held_oe == $past(norm_oe) && held_out == $past(norm_out)));

endmodule

// File: rtl/gpio_pd_pin.sv
module gpio_pd_pin
    import gpio_pd_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       data_bit,
    input  logic       alt_oe,
    input  logic       alt_out,
    input  logic       pad_sync,
    input  logic [1:0] pull_code,
    input  logic [1:0] pdpull_code,
    input  logic [1:0] drv_code,
    input  logic [1:0] pdcfg_code,
    input  logic       asleep,
    input  logic       held_oe,
    input  logic       held_out,
    output logic       norm_oe,
    output logic       norm_out,
    output logic       pad_oe,
    output logic       pad_out,
    output logic       pad_pu,
    output logic       pad_pd,
    output logic [1:0] pad_drv,
    output logic       rd_bit
);
    pin_mode_e  mode_e;
    sleep_cfg_e cfg_e;
    logic [1:0] pull_sel;

    assign mode_e = pin_mode_e'(mode);
    assign cfg_e  = sleep_cfg_e'(pdcfg_code);

    always_comb begin
        unique case (mode_e)
            PM_OUTPUT: begin norm_oe = 1'b1;   norm_out = data_bit; end
            PM_ALT:    begin norm_oe = alt_oe; norm_out = alt_out;  end
            PM_INPUT, PM_RSVD: begin norm_oe = 1'b0; norm_out = 1'b0; end
        endcase
    end

    always_comb begin
        unique case (mode_e)
            PM_OUTPUT:         rd_bit = data_bit;
            PM_ALT:            rd_bit = 1'b0;
            PM_INPUT, PM_RSVD: rd_bit = pad_sync;
        endcase
    end

    always_comb begin
        if (!asleep) begin
            pad_oe  = norm_oe;
            pad_out = norm_out;
        end else begin
            unique case (cfg_e)
                SC_DRIVE0: begin pad_oe = 1'b1;    pad_out = 1'b0;     end
                SC_DRIVE1: begin pad_oe = 1'b1;    pad_out = 1'b1;     end
                SC_FLOAT:  begin pad_oe = 1'b0;    pad_out = 1'b0;     end
                SC_RETAIN: begin pad_oe = held_oe; pad_out = held_out; end
            endcase
        end
    end

    assign pull_sel         = asleep ? pdpull_code : pull_code;
    assign {pad_pu, pad_pd} = pull_decode(pull_sel);
    assign pad_drv          = drive_linear(drv_code);

endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [2*NPINS-1:0]  pin_mode,
    input  logic [NPINS-1:0]    alt_oe,
    input  logic [NPINS-1:0]    alt_out,
    input  logic [NPINS-1:0]    pad_in,
    input  logic                pd_in,
    output logic [NPINS-1:0]    pad_oe,
    output logic [NPINS-1:0]    pad_out,
    output logic [NPINS-1:0]    pad_pu,
    output logic [NPINS-1:0]    pad_pd,
    output logic [2*NPINS-1:0]  pad_drv
);
    logic [NPINS-1:0]   data_q, rd_pins, pad_sync, norm_oe, norm_out;
    logic [NPINS-1:0]   held_oe, held_out;
    logic [2*NPINS-1:0] pull_q, drv_q, pdcfg_q, pdpull_q;
    logic               asleep;

    gpio_pd_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_pins(rd_pins),
        .data_q(data_q), .pull_q(pull_q), .drv_q(drv_q),
        .pdcfg_q(pdcfg_q), .pdpull_q(pdpull_q)
    );

    gpio_pd_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_sync(pad_sync)
    );

    gpio_pd_fsm #(.NPINS(NPINS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_in(pd_in),
        .norm_oe(norm_oe), .norm_out(norm_out),
        .asleep(asleep), .held_oe(held_oe), .held_out(held_out)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pd_pin u_pin (
            .mode(pin_mode[2*i +: 2]), .data_bit(data_q[i]),
            .alt_oe(alt_oe[i]), .alt_out(alt_out[i]), .pad_sync(pad_sync[i]),
            .pull_code(pull_q[2*i +: 2]), .pdpull_code(pdpull_q[2*i +: 2]),
            .drv_code(drv_q[2*i +: 2]), .pdcfg_code(pdcfg_q[2*i +: 2]),
            .asleep(asleep), .held_oe(held_oe[i]), .held_out(held_out[i]),
            .norm_oe(norm_oe[i]), .norm_out(norm_out[i]),
            .pad_oe(pad_oe[i]), .pad_out(pad_out[i]),
            .pad_pu(pad_pu[i]), .pad_pd(pad_pd[i]),
            .pad_drv(pad_drv[2*i +: 2]), .rd_bit(rd_pins[i])
        );

        // R5: the two pulls are never on together
        assert_pull_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[i] && pad_pd[i]));

        // R4: output-mode pin outside sleep drives its stored bit
        assert_run_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!asleep && pin_mode[2*i +: 2] == PM_OUTPUT) |->
            (pad_oe[i] && pad_out[i] == data_q[i]));

        // R6: linear strength keeps the set-bit count of its code
        assert_drive_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(pad_drv[2*i +: 2]) == $countones(drv_q[2*i +: 2]));

        // R8: a retained pin is steady while sleep continues
        assert_retain_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (asleep && $past(asleep) && pdcfg_q[2*i +: 2] == SC_RETAIN &&
             $past(pdcfg_q[2*i +: 2]) == SC_RETAIN) |->
            ($stable(pad_oe[i]) && $stable(pad_out[i])));
    end

endmodule

// File: tb/gpio_pd_port_test.sv
module gpio_pd_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_mode = '0;
    logic [7:0]  alt_oe = '0, alt_out = '0, pad_in = '0;
    logic        pd_in = 1'b0;
    logic [7:0]  pad_oe, pad_out, pad_pu, pad_pd;
    logic [15:0] pad_drv;

    int total = 0;
    int bad = 0;

    gpio_pd_port uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_mode(pin_mode), .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in),
        .pd_in(pd_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_drv(pad_drv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    function automatic logic [15:0] spread(input int off, input int step);
        logic [15:0] w = '0;
        for (int i = 0; i < N; i++) w[2*i +: 2] = 2'((i * step + off) % 4);
        return w;
    endfunction

    function automatic logic [7:0] code_is(input logic [15:0] w, input logic [1:0] c);
        logic [7:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = (w[2*i +: 2] == c);
        return r;
    endfunction

    function automatic logic [15:0] lin(input logic [15:0] w);
        logic [15:0] r;
        for (int i = 0; i < N; i++) begin
            logic [1:0] c = w[2*i +: 2];
            // strength = 2*bit0 + bit1 for codes 00->0,10->1,01->2,11->3
            r[2*i +: 2] = 2'(2 * int'(c[0]) + int'(c[1]));
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_oe(input logic [15:0] m, input logic [7:0] aoe);
        logic [7:0] r;
        for (int i = 0; i < N; i++)
            r[i] = (m[2*i +: 2] == 2'b01) ? 1'b1 : (m[2*i +: 2] == 2'b10) ? aoe[i] : 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] exp_out(input logic [15:0] m, input logic [7:0] d,
                                           input logic [7:0] ao);
        logic [7:0] r;
        for (int i = 0; i < N; i++)
            r[i] = (m[2*i +: 2] == 2'b01) ? d[i] : (m[2*i +: 2] == 2'b10) ? ao[i] : 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] m, input logic [7:0] d,
                                          input logic [7:0] p);
        logic [7:0] r;
        for (int i = 0; i < N; i++)
            r[i] = (m[2*i +: 2] == 2'b01) ? d[i] : (m[2*i +: 2] == 2'b10) ? 1'b0 : p[i];
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] pcfg, ppull, pull_w;
        logic [7:0]  sl_oe, sl_out, keep, d0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 data", v, 32'h0);
        rd(3'd1, v); chk("R1 pull", v, 32'h5555);
        rd(3'd2, v); chk("R1 drive", v, 32'h0);
        rd(3'd3, v); chk("R1 sleep cfg", v, 32'h0);
        rd(3'd4, v); chk("R1 sleep pull", v, 32'h0);
        chk("R1 pad_pd", {24'h0, pad_pd}, 32'hFF);
        chk("R1 pad_pu", {24'h0, pad_pu}, 32'h0);
        chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);

        // R2 map, widths, unused indices
        pin_mode = 16'h5555;
        wr(3'd0, 32'hFFFF_FF3C); wr(3'd1, 32'hFFFF_1234); wr(3'd2, 32'hABCD_9876);
        wr(3'd3, 32'h0000_4321); wr(3'd4, 32'h0F0F_A5A5);
        rd(3'd0, v); chk("R2 data", v, 32'h3C);
        rd(3'd1, v); chk("R2 pull", v, 32'h1234);
        rd(3'd2, v); chk("R2 drive", v, 32'h9876);
        rd(3'd3, v); chk("R2 sleep cfg", v, 32'h4321);
        rd(3'd4, v); chk("R2 sleep pull", v, 32'hA5A5);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            rd(3'(a), v); chk("R2 unused read", v, 32'h0);
        end
        rd(3'd0, v); chk("R2 data kept", v, 32'h3C);
        rd(3'd1, v); chk("R2 pull kept", v, 32'h1234);
        rd(3'd2, v); chk("R2 drive kept", v, 32'h9876);
        rd(3'd3, v); chk("R2 cfg kept", v, 32'h4321);
        rd(3'd4, v); chk("R2 spull kept", v, 32'hA5A5);

        // R5 pull sweep and R6 drive sweep
        for (int off = 0; off < 4; off++) begin
            for (int step = 0; step < 2; step++) begin
                pull_w = spread(off, step);
                wr(3'd1, {16'h0, pull_w});
                chk("R5 pad_pu", {24'h0, pad_pu}, {24'h0, code_is(pull_w, 2'b10)});
                chk("R5 pad_pd", {24'h0, pad_pd}, {24'h0, code_is(pull_w, 2'b01)});
                wr(3'd2, {16'h0, pull_w});
                chk("R6 pad_drv", {16'h0, pad_drv}, {16'h0, lin(pull_w)});
            end
        end

        // R3/R4 mode sweep
        alt_oe = 8'h3C; alt_out = 8'h96; pad_in = 8'h5A;
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 2; j++) begin
                d0 = (j == 0) ? 8'hA5 : 8'h0F;
                pin_mode = spread(k, 1 + j);
                wr(3'd0, {24'h0, d0});
                repeat (3) @(negedge clk);
                chk("R4 pad_oe", {24'h0, pad_oe}, {24'h0, exp_oe(pin_mode, alt_oe)});
                chk("R4 pad_out", {24'h0, pad_out}, {24'h0, exp_out(pin_mode, d0, alt_out)});
                rd(3'd0, v);
                chk("R3 data read", v, {24'h0, exp_rd(pin_mode, d0, pad_in)});
            end
        end

        // R3 synchronizer latency
        pin_mode = 16'h0000; pad_in = 8'h00;
        repeat (4) @(negedge clk);
        pad_in = 8'hFF;
        @(posedge clk); @(negedge clk);
        rd(3'd0, v); chk("R3 second edge old", v, 32'h00);
        rd(3'd0, v); chk("R3 third edge new", v, 32'hFF);

        // R7/R8 sleep entry with outputs
        pcfg = spread(0, 1); ppull = spread(1, 1); pull_w = 16'h0000;
        wr(3'd1, {16'h0, pull_w}); wr(3'd2, 32'h0000_B1E4);
        wr(3'd3, {16'h0, pcfg}); wr(3'd4, {16'h0, ppull});
        pin_mode = 16'h5555; d0 = 8'hCA;
        wr(3'd0, {24'h0, d0});
        keep = code_is(pcfg, 2'b11);
        sl_oe  = code_is(pcfg, 2'b00) | code_is(pcfg, 2'b01) | (keep & 8'hFF);
        sl_out = code_is(pcfg, 2'b01) | (keep & d0);
        pd_in = 1'b1;
        #1 chk("R7 before edge oe", {24'h0, pad_oe}, 32'hFF);
        @(posedge clk); @(negedge clk);
        chk("R7 sleep oe", {24'h0, pad_oe}, {24'h0, sl_oe});
        chk("R7 sleep out", {24'h0, pad_out}, {24'h0, sl_out});
        chk("R7 sleep pu", {24'h0, pad_pu}, {24'h0, code_is(ppull, 2'b10)});
        chk("R7 sleep pd", {24'h0, pad_pd}, {24'h0, code_is(ppull, 2'b01)});
        chk("R6 sleep drv", {16'h0, pad_drv}, {16'h0, lin(16'hB1E4)});
        pin_mode = 16'h0000;
        wr(3'd0, 32'h35);
        repeat (2) @(negedge clk);
        chk("R8 retained oe", {24'h0, pad_oe}, {24'h0, sl_oe});
        chk("R8 retained out", {24'h0, pad_out}, {24'h0, sl_out});

        // R9 wake
        pd_in = 1'b0;
        #1 chk("R9 before edge", {24'h0, pad_out}, {24'h0, sl_out});
        @(posedge clk); @(negedge clk);
        chk("R9 wake oe", {24'h0, pad_oe}, 32'h0);
        chk("R9 wake pd", {24'h0, pad_pd}, 32'h0);
        pin_mode = 16'h5555;
        #1 chk("R9 wake new data", {24'h0, pad_out}, 32'h35);
        @(negedge clk);
        rd(3'd3, v); chk("R9 cfg unchanged", v, {16'h0, pcfg});
        rd(3'd4, v); chk("R9 spull unchanged", v, {16'h0, ppull});
        rd(3'd1, v); chk("R9 pull unchanged", v, {16'h0, pull_w});

        // R8 retention of alternate-function values
        pin_mode = 16'hAAAA; alt_oe = 8'h08; alt_out = 8'h80;
        @(negedge clk);
        pd_in = 1'b1;
        @(posedge clk); @(negedge clk);
        alt_oe = 8'hFF; alt_out = 8'h00;
        repeat (2) @(negedge clk);
        chk("R8 alt retained oe", {24'h0, pad_oe & keep}, 32'h08);
        chk("R8 alt retained out", {24'h0, pad_out & keep}, 32'h80);
        pd_in = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 alt restored oe", {24'h0, pad_oe}, 32'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule